// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block produces the word address for a 32K-word synchronous burst memory port. On every rising clock edge it looks at a 15-bit external address, a processor-side load strobe, a controller-side load strobe, an advance input and three chip enables. A load latches a new base address and evaluates chip select. Later advance pulses step only the two least significant address bits, so each burst covers one aligned group of four words.

The order within the group is chosen at load time. It is either interleaved (the base low bits XORed with a running count) or linear (the base low bits plus the count, wrapping inside the group). Dropping the advance input holds the address, which suspends the burst. A new strobe abandons the current burst at once. When both strobes arrive together, the processor strobe wins. The processor strobe is gated by the primary chip enable. The controller strobe is not.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `selected` is 0, `proc_burst` is 0 and `word_addr` is 0.
- R2: A processor strobe with `ce_main` = 1 loads `ext_addr`. In the next cycle `word_addr` equals that address and `proc_burst` is 1.
- R3: A processor strobe with `ce_main` = 0 and no controller strobe is ignored. `word_addr`, `selected` and `proc_burst` keep their values.
- R4: A controller strobe loads `ext_addr` whatever the level of `ce_main`, and sets `proc_burst` to 0. After any load, `selected` = `ce_main` & `ce_aux_hi` & ~`ce_aux_lo_n`.
- R5: When both strobes are high and `ce_main` = 1, the processor strobe takes the load (`proc_burst` = 1). When both are high and `ce_main` = 0, the controller strobe takes it (`proc_burst` = 0).
- R6: With `linear_order` = 0 at load, each advance cycle while selected gives low address bits equal to base[1:0] XOR k, for k = 1, 2, 3.
- R7: With `linear_order` = 1 at load, the low bits are (base[1:0] + k) mod 4. In both orders, bits [14:2] stay equal to the base for the whole burst.
- R8: A cycle with `advance` = 0 and no load leaves `word_addr` unchanged (suspend). Advancing later resumes from the held position.
- R9: The fourth advance after a load returns the low bits to the base value, because the count wraps modulo 4.
- R10: A strobe in the middle of a burst restarts from the new base with the count at 0.
- R11: Chip enables are only sampled on a load. Changing them during a burst does not change `selected`.
- R12: Advance while deselected does not move `word_addr`.
- R13: `linear_order` is captured on a load. Changing it during a burst does not change the order in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | 15 | External word address presented with a strobe |
| proc_strobe | input | 1 | Processor-side load strobe, active high, gated by `ce_main` |
| ctrl_strobe | input | 1 | Controller-side load strobe, active high |
| advance | input | 1 | Step to the next burst address when high, hold when low |
| ce_main | input | 1 | Primary chip enable, active high |
| ce_aux_hi | input | 1 | Secondary chip enable, active high |
| ce_aux_lo_n | input | 1 | Third chip enable, active low |
| linear_order | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| word_addr | output | 15 | Current array word address |
| selected | output | 1 | Chip-select result from the last load |
| proc_burst | output | 1 | Current burst was started by the processor strobe |

## Verification
A wrong base register shows up as a bad `word_addr` in the cycle right after the load. A wrong burst count or a wrong captured order first appears on the next advance cycle, as a low-bit pair that breaks the XOR or modulo-4 sequence. Nothing is visible while the burst is suspended. A strobe decision that goes wrong is seen one cycle later through `proc_burst` and `selected`. A select flag that is evaluated again mid-burst is seen as soon as an enable moves during an advance.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int unsigned BURST_W = 2;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_PROC = 2'd1,
    LD_CTRL = 2'd2
  } load_e;

  // Low address bits for a given base and count in the chosen order.
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] cnt,
    input logic               linear
  );
    logic [BURST_W-1:0] r;
    if (linear) r = base + cnt;
    else        r = base ^ cnt;
    return r;
  endfunction

  // Combined chip-select evaluation.
  function automatic logic ce_eval(input logic main, input logic aux_hi, input logic aux_lo_n);
    return main & aux_hi & ~aux_lo_n;
  endfunction
endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
  import bas_pkg::*;
(
  input  logic  proc_strobe,
  input  logic  ctrl_strobe,
  input  logic  ce_main,
  output load_e ld_kind
);
  logic proc_ok;
  assign proc_ok = proc_strobe & ce_main;

  always_comb begin
    if (proc_ok)          ld_kind = LD_PROC;
    else if (ctrl_strobe) ld_kind = LD_CTRL;
    else                  ld_kind = LD_NONE;
  end
endmodule

// File: rtl/bas_burst_ctr.sv
module bas_burst_ctr
  import bas_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               advance,
  input  logic               selected,
  input  logic               linear_in,
  output logic [BURST_W-1:0] cnt,
  output logic               linear_q
);
  logic step;
  assign step = ~load & advance & selected;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      linear_q <= 1'b0;
    end else if (load) begin
      cnt      <= '0;
      linear_q <= linear_in;
    end else if (step) begin
      cnt      <= cnt + 1'b1;
    end
  end

  // R6: the count steps by one on each advance while selected
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == BURST_W'($past(cnt) + 1'b1)));

  // R13: the order bit only changes on a load
  assert_order_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(linear_q));
endmodule

// File: rtl/bas_base_reg.sv
module bas_base_reg
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  load_e             ld_kind,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ce_ok,
  output logic [ADDR_W-1:0] base,
  output logic              selected,
  output logic              proc_burst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base       <= '0;
      selected   <= 1'b0;
      proc_burst <= 1'b0;
    end else if (ld_kind != LD_NONE) begin
      base       <= ext_addr;
      selected   <= ce_ok;
      proc_burst <= (ld_kind == LD_PROC);
    end
  end

  // R11: select is only re-evaluated on a load
  assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_kind == LD_NONE) |=> $stable(selected));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              advance,
  input  logic              ce_main,
  input  logic              ce_aux_hi,
  input  logic              ce_aux_lo_n,
  input  logic              linear_order,
  output logic [ADDR_W-1:0] word_addr,
  output logic              selected,
  output logic              proc_burst
);
  localparam int unsigned UPPER_W = ADDR_W - BURST_W;

  load_e              ld_kind;
  logic               load_any;
  logic               ce_ok;
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] cnt;
  logic               linear_q;

  assign ce_ok    = ce_eval(ce_main, ce_aux_hi, ce_aux_lo_n);
  assign load_any = (ld_kind != LD_NONE);

  bas_strobe_arb u_arb (
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .ce_main     (ce_main),
    .ld_kind     (ld_kind)
  );

  bas_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_kind    (ld_kind),
    .ext_addr   (ext_addr),
    .ce_ok      (ce_ok),
    .base       (base),
    .selected   (selected),
    .proc_burst (proc_burst)
  );

  bas_burst_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_any),
    .advance   (advance),
    .selected  (selected),
    .linear_in (linear_order),
    .cnt       (cnt),
    .linear_q  (linear_q)
  );

  assign word_addr = {base[ADDR_W-1:BURST_W], burst_low(base[BURST_W-1:0], cnt, linear_q)};

  // R2 / R10: a load presents the new address in the next cycle
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_any |=> (word_addr == $past(ext_addr)));

  // R3: a gated processor strobe alone changes nothing
  assert_proc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && !ce_main && !ctrl_strobe && !advance) |=>
      ($stable(word_addr) && $stable(selected) && $stable(proc_burst)));

  // R5: the processor strobe wins when enabled
  assert_proc_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && ce_main) |=> proc_burst);

  // R7: upper bits stay fixed within a burst
  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_any |=> (word_addr[ADDR_W-1:BURST_W] == $past(word_addr[ADDR_W-1:BURST_W])));

  // R8 / R12: no load and no effective step holds the address
  assert_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_any && (!advance || !selected)) |=> $stable(word_addr));

  logic [UPPER_W-1:0] unused_upper_chk;
  assign unused_upper_chk = base[ADDR_W-1:BURST_W];
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] ext_addr = '0;
  logic        proc_strobe = 1'b0;
  logic        ctrl_strobe = 1'b0;
  logic        advance = 1'b0;
  logic        ce_main = 1'b0;
  logic        ce_aux_hi = 1'b0;
  logic        ce_aux_lo_n = 1'b1;
  logic        linear_order = 1'b0;
  logic [14:0] word_addr;
  logic        selected;
  logic        proc_burst;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq dut_i (
    .clk (clk), .rst_n (rst_n), .ext_addr (ext_addr),
    .proc_strobe (proc_strobe), .ctrl_strobe (ctrl_strobe), .advance (advance),
    .ce_main (ce_main), .ce_aux_hi (ce_aux_hi), .ce_aux_lo_n (ce_aux_lo_n),
    .linear_order (linear_order), .word_addr (word_addr), .selected (selected),
    .proc_burst (proc_burst)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench model of the address, written from the requirements.
  function automatic int model_addr(input int base, input int k, input bit lin);
    int lo;
    if (lin) lo = ((base % 4) + k) % 4;
    else begin
      lo = 0;
      if (((base >> 1) & 1) != ((k >> 1) & 1)) lo += 2;
      if ((base & 1) != (k & 1)) lo += 1;
    end
    return (base / 4) * 4 + lo;
  endfunction

  task automatic idle();
    proc_strobe = 0; ctrl_strobe = 0; advance = 0;
  endtask

  task automatic enable_all();
    ce_main = 1; ce_aux_hi = 1; ce_aux_lo_n = 0;
  endtask

  task automatic t_reset();
    check("R1 selected", selected, 0);
    check("R1 proc_burst", proc_burst, 0);
    check("R1 word_addr", word_addr, 0);
  endtask

  task automatic t_interleaved();
    int b = 'h1236;
    enable_all(); linear_order = 0; ext_addr = b; proc_strobe = 1;
    cyc(); idle();
    check("R2 load addr", word_addr, b);
    check("R2 proc_burst", proc_burst, 1);
    check("R4 selected", selected, 1);
    advance = 1;
    for (int k = 1; k < 4; k++) begin
      cyc();
      check("R6 interleaved step", word_addr, model_addr(b, k, 0));
    end
    cyc();
    check("R9 wrap to base", word_addr, b);
    idle();
  endtask

  task automatic t_linear();
    int b = 'h4A53;
    enable_all(); linear_order = 1; ext_addr = b; ctrl_strobe = 1;
    cyc(); idle();
    check("R4 ctrl load addr", word_addr, b);
    check("R4 ctrl proc_burst", proc_burst, 0);
    linear_order = 0;
    advance = 1;
    for (int k = 1; k < 4; k++) begin
      cyc();
      check("R7 R13 linear step", word_addr, model_addr(b, k, 1));
    end
    idle();
  endtask

  task automatic t_suspend();
    int b = 'h0F01;
    enable_all(); linear_order = 1; ext_addr = b; proc_strobe = 1;
    cyc(); idle();
    advance = 1; cyc(); advance = 0;
    check("R8 first step", word_addr, model_addr(b, 1, 1));
    for (int i = 0; i < 3; i++) begin
      cyc();
      check("R8 held", word_addr, model_addr(b, 1, 1));
    end
    advance = 1; cyc(); advance = 0;
    check("R8 resume", word_addr, model_addr(b, 2, 1));
  endtask

  task automatic t_restart();
    int b1 = 'h2220;
    int b2 = 'h7FFE;
    enable_all(); linear_order = 0; ext_addr = b1; proc_strobe = 1;
    cyc(); idle();
    advance = 1; cyc(); cyc();
    ext_addr = b2; ctrl_strobe = 1; linear_order = 1;
    cyc(); ctrl_strobe = 0;
    check("R10 restart base", word_addr, b2);
    cyc();
    check("R10 restart count", word_addr, model_addr(b2, 1, 1));
    idle();
  endtask

  task automatic t_ignore_proc();
    int a0, s0, p0;
    a0 = word_addr; s0 = selected; p0 = proc_burst;
    ce_main = 0; ext_addr = 'h5555; proc_strobe = 1;
    cyc(); cyc(); idle();
    check("R3 addr kept", word_addr, a0);
    check("R3 sel kept", selected, s0);
    check("R3 proc_burst kept", proc_burst, p0);
  endtask

  task automatic t_deselect();
    int b = 'h3003;
    ce_main = 0; ce_aux_hi = 1; ce_aux_lo_n = 0; ext_addr = b; ctrl_strobe = 1;
    cyc(); idle();
    check("R4 deselect", selected, 0);
    advance = 1; cyc(); cyc(); advance = 0;
    check("R12 no move deselected", word_addr, b);
    enable_all(); ce_aux_lo_n = 1; ext_addr = 'h1000; proc_strobe = 1;
    cyc(); idle();
    check("R4 lo_n disables", selected, 0);
  endtask

  task automatic t_priority();
    enable_all(); ext_addr = 'h0100; proc_strobe = 1; ctrl_strobe = 1;
    cyc(); idle();
    check("R5 proc wins", proc_burst, 1);
    ce_main = 0; ext_addr = 'h0200; proc_strobe = 1; ctrl_strobe = 1;
    cyc(); idle();
    check("R5 ctrl wins when gated", proc_burst, 0);
    check("R5 ctrl address", word_addr, 'h0200);
    check("R5 ctrl deselect", selected, 0);
  endtask

  task automatic t_ce_hold();
    int b = 'h6661;
    enable_all(); linear_order = 0; ext_addr = b; proc_strobe = 1;
    cyc(); idle();
    ce_aux_hi = 0; ce_main = 0; advance = 1;
    cyc(); advance = 0;
    check("R11 sel kept", selected, 1);
    check("R11 still steps", word_addr, model_addr(b, 1, 0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_interleaved();
    t_linear();
    t_suspend();
    t_restart();
    t_ignore_proc();
    t_deselect();
    t_priority();
    t_ce_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule